// File: doc/BRIEF.md
# Programmed-I/O SPI Word Master

This block is a register-mapped SPI master that moves one word at a time under software control. A small register window sits in 64-bit slots, so the register index is taken from address bits 5:3. Software writes the configuration register to choose the clock polarity and phase, the chip-select polarity, the word length, the transfer direction and one of four chip-select lines. It then sets the enable bit, which drives the chosen chip select active and holds it there across any number of words.

Each word starts when software writes the transmit data register. The word shifts out MSB first on `spiMosi`, and `spiMiso` is sampled on the opposite clock edge. Once the last clock edge has passed, the received word can be read from the receive data register, unless the word ran in transmit-only mode. A receive-only word is started by writing any value to the transmit data register, and in that mode `spiMosi` stays low.

The serial clock rate comes from the `divCount` input, which is latched at the start of each word. `spiSclk` toggles once every `divCount` system clocks. Status flags report whether a word is in flight and whether a received word is waiting. The FIFO status bits describe the single transmit and receive holding registers.

Top module: `spi_word_master`

## Requirements
- R1: After reset the configuration register is zero, `spiSclk` and `spiMosi` are low, every chip-select line is high (inactive), and the status register reads 0x56.
- R2: Register index = address bits 5:3, where 0 = configuration, 1 = status, 2 = FIFO control, 3 = transmit data and 4 = receive data. Configuration fields are:
  - bit 0: phase
  - bit 1: polarity
  - bit 2: chip-select polarity
  - bit 3: transmission enable
  - bits 8:4: length minus one
  - bits 13:12: mode
  - bits 17:14: chip-select number
  - bits 24:18: word count
  - bit 25: FIFO enable
  - bit 26: enable

  Bits 11:9 and 31:27 read as zero. The FIFO control register reads as zero, and the transmit data index reads as zero.
- R3: Chip-select line i is at the level of config bit 2 when config bit 26 is set and bits 17:14 equal i. Otherwise it is at the inverse of that level. Numbers 4 and above select no line.
- R4: A write to the transmit data register starts a word only while config bit 26 is set and no word is in progress. Any other such write is ignored.
- R5: While idle, `spiSclk` follows config bit 1. In a word of N bits, `spiSclk` toggles 2N times. The first toggle comes D clocks after the accepting edge and each later toggle D clocks after the one before, where D is `divCount` latched at the start (0 counts as 1).
- R6: The word length is config bits 8:4 plus one. Field values below 3 give 4 bits. Transmit data bits N-1 down to 0 appear on `spiMosi` in that order.
- R7: With phase 0, MISO is sampled on the odd-numbered toggles and MOSI advances on the even-numbered ones. With phase 1, MOSI advances on the odd-numbered toggles after the first and MISO is sampled on the even-numbered ones.
- R8: Mode (config bits 13:12) selects the direction:
  - 0 and 3: full duplex
  - 1: receive-only, with `spiMosi` held low for the word
  - 2: transmit-only; the receive data register and receive-ready flag are left unchanged
- R9: At the last toggle of a non-transmit-only word, the N sampled bits (first sample in bit N-1, upper bits zero) are stored in the receive data register and status bit 0 is set. A read of the receive data register clears bit 0; a completion in the same cycle wins.
- R10: Status bits are as follows. While a word is in progress, bits 1, 2 and 4 are 0 and bit 5 is 1; otherwise bits 1, 2 and 4 are 1 and bit 5 is 0. Bit 0 = receive ready, bit 6 = its inverse, bit 7 = receive ready. All other bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| divCount | input | DIV_W | System clocks per serial clock half period |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (side effect on receive data) |
| regAddr | input | 6 | Byte address; bits 5:3 pick the register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr`, combinational |
| spiSclk | output | 1 | Serial clock |
| spiMosi | output | 1 | Serial data out |
| spiMiso | input | 1 | Serial data in |
| spiCs | output | NUM_CS | Chip-select lines, polarity set by config bit 2 |

## Verification
The bench drives MISO from a pseudo-random sequence and checks the serial pins every cycle against a behavioural model. It runs all four polarity and phase pairs, lengths of 4, 6, 8, 13, 16 and 32 bits, a length field below the minimum, and divider values of 0, 1, 2, 3, 4 and 300.

Several corner cases get their own attention:
- Phase 1 takes its last sample on the final toggle. A design that captured the word before that sample would return every received word shifted by one bit.
- A transmit write during a word would corrupt the MOSI stream if it were not ignored.
- A write while disabled would start clocks with no chip select active.
- Transmit-only mode would wrongly raise receive-ready or overwrite the receive register.
- A length field below 3 would give too few clock toggles if it were not clamped.

// File: rtl/spi_word_pkg.sv
package spi_word_pkg;

  typedef enum logic [2:0] {
    IDX_CFG  = 3'd0,
    IDX_STAT = 3'd1,
    IDX_FCTL = 3'd2,
    IDX_TX   = 3'd3,
    IDX_RX   = 3'd4
  } regIdx_e;

  typedef enum logic [1:0] {
    MODE_DUPLEX = 2'd0,
    MODE_RXONLY = 2'd1,
    MODE_TXONLY = 2'd2,
    MODE_SPARE  = 2'd3
  } xferMode_e;

  typedef struct packed {
    logic       spiEn;
    logic       fifoEn;
    logic [6:0] wordCnt;
    logic [3:0] csNum;
    logic [1:0] mode;
    logic [4:0] lenM1;
    logic       txEn;
    logic       csPol;
    logic       cpol;
    logic       cpha;
  } cfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic rxOnly;
    logic idle;
    logic edgeTick;
    logic sample;
    logic shift;
    logic capture;
  } dpStrobe_t;

  function automatic logic [31:0] cfgToWord(cfg_t c);
    logic [31:0] w;
    w        = '0;
    w[0]     = c.cpha;
    w[1]     = c.cpol;
    w[2]     = c.csPol;
    w[3]     = c.txEn;
    w[8:4]   = c.lenM1;
    w[13:12] = c.mode;
    w[17:14] = c.csNum;
    w[24:18] = c.wordCnt;
    w[25]    = c.fifoEn;
    w[26]    = c.spiEn;
    return w;
  endfunction

  function automatic cfg_t wordToCfg(logic [31:0] w);
    cfg_t c;
    c.cpha    = w[0];
    c.cpol    = w[1];
    c.csPol   = w[2];
    c.txEn    = w[3];
    c.lenM1   = w[8:4];
    c.mode    = w[13:12];
    c.csNum   = w[17:14];
    c.wordCnt = w[24:18];
    c.fifoEn  = w[25];
    c.spiEn   = w[26];
    return c;
  endfunction

endpackage

// File: rtl/spi_word_ctrl.sv
module spi_word_ctrl
  import spi_word_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int MAX_W = 32,
  parameter int LEN_W = $clog2(MAX_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  divCount,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [5:0]        regAddr,
  input  logic [31:0]       regWrData,
  input  logic [MAX_W-1:0]  rxHold,
  output logic [31:0]       regRdData,
  output cfg_t              cfgQ,
  output dpStrobe_t         stb,
  output logic [LEN_W-1:0]  wordBits,
  output logic              busyQ,
  output logic              rxReadyQ
);

  localparam int EDGE_W = LEN_W + 1;

  logic [DIV_W-1:0]  divCnt;
  logic [DIV_W-1:0]  divLatch;
  logic [EDGE_W-1:0] edgeCnt;
  logic [EDGE_W-1:0] lastEdge;
  logic [2:0]        idx;
  logic              wrCfg, wrTx, rdRx, accept;
  logic              tick, leading, sampleEdge, finish;
  logic [2:0]        unusedAddrLow;

  assign idx           = regAddr[5:3];
  assign unusedAddrLow = regAddr[2:0];
  assign wrCfg         = regWrEn && (idx == IDX_CFG);
  assign wrTx          = regWrEn && (idx == IDX_TX);
  assign rdRx          = regRdEn && (idx == IDX_RX);
  assign accept        = wrTx && cfgQ.spiEn && !busyQ;

  // effective word length, clamped to [4, MAX_W]
  always_comb begin
    if (cfgQ.lenM1 < 5'd3)
      wordBits = LEN_W'(4);
    else if (int'(cfgQ.lenM1) >= MAX_W)
      wordBits = LEN_W'(MAX_W);
    else
      wordBits = LEN_W'(cfgQ.lenM1) + LEN_W'(1);
  end

  assign lastEdge   = {wordBits, 1'b0} - EDGE_W'(1);
  assign tick       = busyQ && (divCnt == divLatch - DIV_W'(1));
  assign leading    = !edgeCnt[0];
  assign sampleEdge = cfgQ.cpha ? !leading : leading;
  assign finish     = tick && (edgeCnt == lastEdge);

  always_comb begin
    stb          = '0;
    stb.load     = accept;
    stb.rxOnly   = (cfgQ.mode == MODE_RXONLY);
    stb.idle     = !busyQ;
    stb.edgeTick = tick;
    stb.sample   = tick && sampleEdge;
    stb.shift    = tick && !sampleEdge && (edgeCnt != '0);
    stb.capture  = finish && (cfgQ.mode != MODE_TXONLY);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ     <= '0;
      busyQ    <= 1'b0;
      divCnt   <= '0;
      divLatch <= DIV_W'(1);
      edgeCnt  <= '0;
      rxReadyQ <= 1'b0;
    end else begin
      if (wrCfg) cfgQ <= wordToCfg(regWrData);
      if (accept) begin
        busyQ    <= 1'b1;
        divCnt   <= '0;
        edgeCnt  <= '0;
        divLatch <= (divCount == '0) ? DIV_W'(1) : divCount;
      end else if (busyQ) begin
        if (tick) begin
          divCnt  <= '0;
          edgeCnt <= edgeCnt + EDGE_W'(1);
          if (finish) busyQ <= 1'b0;
        end else begin
          divCnt <= divCnt + DIV_W'(1);
        end
      end
      if (stb.capture)
        rxReadyQ <= 1'b1;
      else if (rdRx)
        rxReadyQ <= 1'b0;
    end
  end

  always_comb begin
    case (idx)
      IDX_CFG:  regRdData = cfgToWord(cfgQ);
      IDX_STAT: regRdData = {24'd0, rxReadyQ, !rxReadyQ, busyQ, !busyQ,
                             1'b0, !busyQ, !busyQ, rxReadyQ};
      IDX_RX:   regRdData = 32'(rxHold);
      default:  regRdData = '0;
    endcase
  end

endmodule

// File: rtl/spi_word_dp.sv
module spi_word_dp
  import spi_word_pkg::*;
#(
  parameter int MAX_W = 32,
  parameter int LEN_W = $clog2(MAX_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic [MAX_W-1:0] txWord,
  input  logic [LEN_W-1:0] wordBits,
  input  logic             cpol,
  input  logic             miso,
  output logic             sclk,
  output logic             mosi,
  output logic [MAX_W-1:0] rxHold
);

  logic [MAX_W-1:0] shReg;
  logic [MAX_W-1:0] rxSh;
  logic [MAX_W-1:0] rxNext;
  logic             sclkQ;

  assign rxNext = stb.sample ? {rxSh[MAX_W-2:0], miso} : rxSh;
  assign mosi   = shReg[MAX_W-1];
  assign sclk   = sclkQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg  <= '0;
      rxSh   <= '0;
      rxHold <= '0;
      sclkQ  <= 1'b0;
    end else begin
      if (stb.idle)
        sclkQ <= cpol;
      else if (stb.edgeTick)
        sclkQ <= ~sclkQ;

      if (stb.load) begin
        shReg <= stb.rxOnly ? '0 : (txWord << (LEN_W'(MAX_W) - wordBits));
        rxSh  <= '0;
      end else begin
        if (stb.shift) shReg <= {shReg[MAX_W-2:0], 1'b0};
        rxSh <= rxNext;
      end

      if (stb.capture) rxHold <= rxNext;
    end
  end

endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
  import spi_word_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int MAX_W  = 32,
  parameter int NUM_CS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  divCount,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [5:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              spiSclk,
  output logic              spiMosi,
  input  logic              spiMiso,
  output logic [NUM_CS-1:0] spiCs
);

  localparam int LEN_W = $clog2(MAX_W + 1);

  cfg_t             cfgQ;
  dpStrobe_t        stb;
  logic [LEN_W-1:0] wordBits;
  logic [MAX_W-1:0] rxHold;
  logic             busyQ;
  logic             rxReadyQ;

  spi_word_ctrl #(.DIV_W(DIV_W), .MAX_W(MAX_W), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .divCount(divCount),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .rxHold(rxHold), .regRdData(regRdData),
    .cfgQ(cfgQ), .stb(stb), .wordBits(wordBits),
    .busyQ(busyQ), .rxReadyQ(rxReadyQ)
  );

  spi_word_dp #(.MAX_W(MAX_W), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .txWord(regWrData[MAX_W-1:0]), .wordBits(wordBits),
    .cpol(cfgQ.cpol), .miso(spiMiso),
    .sclk(spiSclk), .mosi(spiMosi), .rxHold(rxHold)
  );

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign spiCs[i] = (cfgQ.spiEn && (cfgQ.csNum == 4'(i))) ? cfgQ.csPol : ~cfgQ.csPol;
  end

endmodule

// File: rtl/spi_word_master_chk.sv
module spi_word_master_chk
  import spi_word_pkg::*;
#(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rstN,
  input cfg_t              cfgQ,
  input dpStrobe_t         stb,
  input logic              busyQ,
  input logic              rxReadyQ,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [5:0]        regAddr,
  input logic              spiSclk,
  input logic [NUM_CS-1:0] spiCs
);

  // R5
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busyQ |=> (spiSclk == $past(cfgQ.cpol)));

  // R3
  cs_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(spiCs ^ {NUM_CS{~cfgQ.csPol}}));

  // R4
  accept_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr[5:3] == 3'd3 && !cfgQ.spiEn && !busyQ) |=> !busyQ);

  // R9
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr[5:3] == 3'd4 && !stb.capture) |=> !rxReadyQ);

  // R8
  txonly_no_rx_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.edgeTick && cfgQ.mode == 2'd2 && !rxReadyQ) |=> !rxReadyQ);

endmodule

bind spi_word_master spi_word_master_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rstN(rstN), .cfgQ(cfgQ), .stb(stb), .busyQ(busyQ),
  .rxReadyQ(rxReadyQ), .regWrEn(regWrEn), .regRdEn(regRdEn),
  .regAddr(regAddr), .spiSclk(spiSclk), .spiCs(spiCs)
);

// File: tb/test_spi_word_master.sv
`timescale 1ns/1ps
module test_spi_word_master;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] divCount = 16'd1;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        spiSclk, spiMosi;
  logic        spiMiso;
  logic [3:0]  spiCs;
  logic [15:0] lfsr = 16'hACE1;

  int nChecks = 0;
  int nFails  = 0;
  bit cmpOn   = 0;
  bit ended   = 0;

  always #5 clk = ~clk;

  spi_word_master i_spi_word_master (
    .clk(clk), .rstN(rstN), .divCount(divCount),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .spiSclk(spiSclk), .spiMosi(spiMosi), .spiMiso(spiMiso), .spiCs(spiCs)
  );

  // pseudo-random slave data, changed away from the active edge
  assign spiMiso = lfsr[0];
  always @(negedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

  // ---------------- behavioural reference model ----------------
  bit          mBusy, mRxReady, mSclk, mAcc, mLead, mSamp;
  int          mDc, mDiv, mEdge, mLen, mIdx, mMode, mWl;
  logic [31:0] mCfg, mRxData;
  longint      mRxAcc;
  bit          txQ[$];

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mRxReady = 0; mSclk = 0; mDc = 0; mDiv = 1; mEdge = 0;
      mLen = 4; mCfg = '0; mRxData = '0; mRxAcc = 0; txQ.delete();
    end else begin
      mIdx = int'(regAddr[5:3]);
      mAcc = regWrEn && mIdx == 3 && mCfg[26] && !mBusy;
      if (regRdEn && mIdx == 4) mRxReady = 0;
      if (!mBusy) mSclk = mCfg[1];
      else if (mDc == mDiv - 1) begin
        mDc = 0; mEdge++; mSclk = !mSclk;
        mLead = (mEdge % 2) == 1;
        mSamp = mCfg[0] ? !mLead : mLead;
        if (mSamp) mRxAcc = mRxAcc * 2 + longint'(spiMiso);
        else if (mEdge > 1 && txQ.size() > 0) void'(txQ.pop_front());
        if (mEdge == 2 * mLen) begin
          mBusy = 0;
          if (mCfg[13:12] != 2'd2) begin mRxReady = 1; mRxData = mRxAcc[31:0]; end
        end
      end else mDc++;
      if (mAcc) begin
        mWl   = int'(mCfg[8:4]);
        mLen  = (mWl < 3) ? 4 : mWl + 1;
        mMode = int'(mCfg[13:12]);
        mDiv  = (divCount == 0) ? 1 : int'(divCount);
        mDc = 0; mEdge = 0; mBusy = 1; mRxAcc = 0;
        txQ.delete();
        for (int b = mLen - 1; b >= 0; b--) txQ.push_back(mMode == 1 ? 1'b0 : regWrData[b]);
      end
      if (regWrEn && mIdx == 0) mCfg = regWrData;
    end
  end

  function automatic logic [31:0] expStatus();
    return {24'd0, mRxReady, !mRxReady, mBusy, !mBusy, 1'b0, !mBusy, !mBusy, mRxReady};
  endfunction

  function automatic logic [3:0] expCs();
    logic [3:0] v;
    for (int i = 0; i < 4; i++)
      v[i] = (mCfg[26] && mCfg[17:14] == 4'(i)) ? mCfg[2] : !mCfg[2];
    return v;
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", what, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison of the serial pins
  always @(negedge clk) begin
    if (cmpOn && !ended) begin
      chk("R5 sclk", 32'(spiSclk), 32'(mSclk));
      chk("R6 R7 R8 mosi", 32'(spiMosi), (txQ.size() > 0) ? 32'(txQ[0]) : 32'd0);
      chk("R3 chip select", 32'(spiCs), 32'(expCs()));
    end
  end

  task automatic wrReg(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); regRdEn = 1'b1; regAddr = a; #1 d = regRdData;
    @(negedge clk); regRdEn = 1'b0;
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  logic [31:0] rd, st;
  int cpolT[8]  = '{0, 0, 1, 1, 0, 1, 0, 1};
  int cphaT[8]  = '{0, 1, 0, 1, 0, 0, 1, 1};
  int lenT[8]   = '{7, 7, 12, 31, 0, 15, 3, 5};
  int modeT[8]  = '{0, 0, 1, 0, 0, 2, 3, 0};
  int divT[8]   = '{1, 2, 3, 1, 2, 0, 4, 300};
  logic [31:0] dataT[8] = '{32'hA5, 32'h3C, 32'h1ABC, 32'hDEADBEEF,
                            32'h9, 32'h1234, 32'hB, 32'h2A};

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sclk", 32'(spiSclk), 32'd0);
    chk("R1 mosi", 32'(spiMosi), 32'd0);
    chk("R1 cs", 32'(spiCs), 32'hF);
    rdReg(6'h08, rd); chk("R1 status", rd, 32'h56);
    rdReg(6'h00, rd); chk("R1 config", rd, 32'h0);
    cmpOn = 1;

    // R2 register map and reserved bits
    wrReg(6'h00, 32'hFFFF_FFFF);
    rdReg(6'h00, rd); chk("R2 config readback", rd, 32'h07FF_F1FF);
    rdReg(6'h04, rd); chk("R2 index from bits 5:3", rd, 32'h07FF_F1FF);
    wrReg(6'h00, 32'h0);
    wrReg(6'h10, 32'h1);
    rdReg(6'h10, rd); chk("R2 fifo control reads zero", rd, 32'h0);

    // R4 write while disabled is ignored
    wrReg(6'h00, 32'h0000_0070);
    wrReg(6'h18, 32'hFF);
    repeat (4) @(negedge clk);
    rdReg(6'h08, rd); chk("R4 disabled write ignored", rd, 32'h56);
    chk("R4 sclk idle", 32'(spiSclk), 32'd0);

    for (int t = 0; t < 8; t++) begin
      logic [31:0] cfg;
      cfg = (32'd1 << 26) | (32'(t % 4) << 14) | (32'(modeT[t]) << 12) |
            (32'(lenT[t]) << 4) | (32'(t % 2) << 2) | (32'(cpolT[t]) << 1) | 32'(cphaT[t]);
      divCount = 16'(divT[t]);
      wrReg(6'h00, cfg);
      repeat (2) @(negedge clk);
      wrReg(6'h18, dataT[t]);
      rdReg(6'h08, st);
      chk("R10 status while busy", st, expStatus());
      chk("R10 busy flag", 32'(st[5]), 32'd1);
      wrReg(6'h18, ~dataT[t]);   // R4 ignored while busy; pins compared each cycle
      while (mBusy) @(negedge clk);
      repeat (2) @(negedge clk);
      rdReg(6'h08, st);
      chk("R10 status after word", st, expStatus());
      chk("R10 end of transfer", 32'(st[2]), 32'd1);
      if (modeT[t] == 2) begin
        chk("R8 tx-only leaves rx ready low", 32'(st[0]), 32'd0);
        rdReg(6'h20, rd);
        chk("R8 tx-only keeps rx register", rd, mRxData);
      end else begin
        chk("R9 rx ready set", 32'(st[0]), 32'd1);
        rdReg(6'h20, rd);
        chk("R7 R9 rx word", rd, mRxData);
        rdReg(6'h08, st);
        chk("R9 rx ready cleared by read", 32'(st[0]), 32'd0);
      end
      wrReg(6'h00, cfg & ~(32'd1 << 26));
      repeat (2) @(negedge clk);
      chk("R3 cs released", 32'(spiCs), 32'(expCs()));
    end

    // R3 chip-select number out of range selects none
    wrReg(6'h00, (32'd1 << 26) | (32'd9 << 14));
    @(negedge clk);
    chk("R3 out-of-range select", 32'(spiCs), 32'hF);

    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule